// File: doc/BRIEF.md
# Time-Triggered Bank-Group DRAM Scheduler

This block issues DRAM commands for a module whose banks sit in two ranks that share only the command bus and the data bus. It splits those banks into four private groups, and each group belongs to exactly one requester, for example one hardware thread. A fixed rotation gives each group one slot of `SLOT_LEN` cycles. The rotation runs whether or not anyone is waiting. In each slot the block plays one of three static command patterns for the owning group: read, write or refresh. If there is nothing to do, the slot is left idle.

Every access opens its row and closes it again through auto-precharge, so the row that was open before has no effect on timing. A requester's latency is set only by where its slot falls in the rotation. Traffic from other groups never changes it. A refresh pulse claims the next slot to start. That slot activates and precharges the next refresh row of the owning group, and that group's own request moves to its following slot.

The slot sequencer is a four-state machine. `ST_ACT` lasts one cycle and opens the row. `ST_RCD` holds for the remaining activate-to-column cycles. `ST_CAS` lasts one cycle and issues the column command or the precharge. `ST_TAIL` fills the rest of the slot. The transitions are:
- ACT to RCD, or ACT to CAS when `T_RCD` is 1.
- RCD to CAS when its count ends.
- CAS to TAIL.
- TAIL to ACT of the next group when its count ends.

Reset parks the machine at the end of `ST_TAIL` of group 3, so the first slot after reset belongs to group 0.

Top module: `tt_bank_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_o` is NOP (code 0), and `req_take` and `rd_valid` are all zero.
- R2: Group g's slot starts in cycle 4*SLOT_LEN*k + g*SLOT_LEN after reset for every k ≥ 0, whatever the traffic. A request raised during cycle c is accepted (`req_take[g]` high for one cycle) at the first slot start of group g that is at or after cycle c+1.
- R3: Every ACT in group g's slot drives `cmd_rank` = g bit 0 and `cmd_bank` = g bit 1, so consecutive slots alternate ranks.
- R4: A slot whose group has no request and no refresh drives NOP for all its cycles and asserts no `req_take`.
- R5: A read slot drives ACT (code 1) with the row on `cmd_addr` in its first cycle, then RD (code 2) with the column and `cmd_ap` = 1 exactly T_RCD cycles later. It drives NOP in all other cycles.
- R6: A write slot uses the same timing as a read slot, but its column command is WR (code 3). In the WR cycle `dq_oe` = 1 and `dq_out` carries the write data. At all other times `dq_oe` = 0.
- R7: For a read, `rd_valid[g]` is high for exactly one cycle, T_RCD+RD_LAT+1 cycles after the slot start. `rd_data` then holds the value that `dq_in` carried RD_LAT cycles after the RD command.
- R8: A one-cycle `ref_req` during cycle c claims the slot that starts at or after c+2. That slot drives ACT with the owning group's refresh row and then PRE (code 4) T_RCD cycles later, and it accepts no request. That group's pending request is accepted one full rotation later. Each group keeps its own refresh row counter, which starts at 0 and advances by one per refresh of that group.
- R9: When all four groups request in the same cycle, each group is still accepted at its own slot and sees the same read latency as when it is alone.
- R10: A read returns the data most recently written to the same group, row and column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 4 | Request pending, one bit per group; held until taken |
| req_write | input | 4 | 1 = write, 0 = read, per group |
| req_row | input | 4*ROW_W | Row address, group g in slice g |
| req_col | input | 4*COL_W | Column address, group g in slice g |
| req_wdata | input | 4*DATA_W | Write data, group g in slice g |
| ref_req | input | 1 | One-cycle refresh request |
| req_take | output | 4 | Request accepted, one-cycle pulse in the ACT cycle |
| rd_valid | output | 4 | Read data valid for group g |
| rd_data | output | DATA_W | Read data return |
| cmd_o | output | 3 | Command: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE |
| cmd_rank | output | 1 | Rank select |
| cmd_bank | output | BANK_W | Bank select |
| cmd_addr | output | max(ROW_W,COL_W) | Row on ACT, column on RD/WR |
| cmd_ap | output | 1 | Auto-precharge with RD/WR |
| dq_out | output | DATA_W | Write data to the device |
| dq_oe | output | 1 | Write data drive enable |
| dq_in | input | DATA_W | Read data from the device |

## Verification
The case that is hardest to reach from the ports is a refresh that takes a slot while that same group already has a request waiting, and at the same moment another group is also waiting. The bench lines up on the rotation counter and pulses `ref_req` exactly two cycles before group 1's slot. In that same cycle it raises requests on groups 1 and 2. It then checks three things: the refresh pattern appears in group 1's slot, group 1 is accepted one rotation later, and group 2 keeps its normal slot. Further refreshes are aimed at group 0 and again at group 1 to show that each group's refresh row counter is separate. A behavioural device model stores writes and replays reads with the fixed latency, so the returned data is checked end to end.

// File: rtl/tt_sched_pkg.sv
package tt_sched_pkg;
    localparam int GROUPS = 4;
    localparam int GRP_W  = 2;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        K_IDLE,
        K_READ,
        K_WRITE,
        K_REFRESH
    } kind_e;

    typedef enum logic [1:0] {
        ST_ACT,
        ST_RCD,
        ST_CAS,
        ST_TAIL
    } slot_st_e;
endpackage

// File: rtl/tt_rotor.sv
module tt_rotor
    import tt_sched_pkg::*;
#(
    parameter int SLOT_LEN = 4,
    parameter int T_RCD    = 2
) (
    input  logic             clk,
    input  logic             rst,
    output slot_st_e         state_o,
    output logic [GRP_W-1:0] grp_o,
    output logic [GRP_W-1:0] nxt_grp_o,
    output logic             enter_o
);
    localparam int TAIL      = SLOT_LEN - T_RCD - 1;
    localparam int CNT_W     = $clog2(SLOT_LEN + 1);
    localparam int RCD_LOAD  = (T_RCD > 1) ? T_RCD - 2 : 0;
    localparam int TAIL_LOAD = (TAIL > 0) ? TAIL - 1 : 0;

    slot_st_e         state, state_n;
    logic [CNT_W-1:0] left, left_n;
    logic [GRP_W-1:0] grp, grp_n;

    always_comb begin
        state_n = state;
        left_n  = left;
        grp_n   = grp;
        unique case (state)
            ST_ACT: begin
                if (T_RCD > 1) begin
                    state_n = ST_RCD;
                    left_n  = CNT_W'(RCD_LOAD);
                end else begin
                    state_n = ST_CAS;
                end
            end
            ST_RCD: begin
                if (left == '0) state_n = ST_CAS;
                else            left_n  = left - 1'b1;
            end
            ST_CAS: begin
                state_n = ST_TAIL;
                left_n  = CNT_W'(TAIL_LOAD);
            end
            ST_TAIL: begin
                if (left == '0) begin
                    state_n = ST_ACT;
                    grp_n   = grp + 1'b1;
                end else begin
                    left_n = left - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_TAIL;
            left  <= '0;
            grp   <= GRP_W'(GROUPS - 1);
        end else begin
            state <= state_n;
            left  <= left_n;
            grp   <= grp_n;
        end
    end

    assign state_o   = state;
    assign grp_o     = grp;
    assign nxt_grp_o = grp + 1'b1;
    assign enter_o   = (state == ST_TAIL) && (left == '0);
endmodule

// File: rtl/tt_refresh.sv
module tt_refresh
    import tt_sched_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_req,
    input  logic             consume,
    input  logic [GRP_W-1:0] sel_grp,
    output logic             pend_o,
    output logic [ROW_W-1:0] row_o
);
    logic             pend;
    logic [ROW_W-1:0] rows [GROUPS];

    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= (pend & ~consume) | ref_req;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst)
                rows[g] <= '0;
            else if (consume && (sel_grp == GRP_W'(g)))
                rows[g] <= rows[g] + 1'b1;
        end
    end

    assign pend_o = pend;
    assign row_o  = rows[sel_grp];
endmodule

// File: rtl/tt_rdret.sv
module tt_rdret
    import tt_sched_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RD_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [GRP_W-1:0]  grp,
    input  logic [DATA_W-1:0] dq_in,
    output logic [GROUPS-1:0] rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [RD_LAT-1:0] v_sr;
    logic [GRP_W-1:0]  g_sr [RD_LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            v_sr <= '0;
            for (int i = 0; i < RD_LAT; i++) g_sr[i] <= '0;
        end else begin
            for (int i = RD_LAT - 1; i > 0; i--) begin
                v_sr[i] <= v_sr[i-1];
                g_sr[i] <= g_sr[i-1];
            end
            v_sr[0] <= issue;
            g_sr[0] <= grp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= '0;
            rd_data  <= '0;
        end else begin
            rd_valid <= '0;
            if (v_sr[RD_LAT-1]) begin
                rd_valid[g_sr[RD_LAT-1]] <= 1'b1;
                rd_data                  <= dq_in;
            end
        end
    end
endmodule

// File: rtl/tt_bank_sched.sv
module tt_bank_sched
    import tt_sched_pkg::*;
#(
    parameter int ROW_W    = 14,
    parameter int COL_W    = 10,
    parameter int DATA_W   = 32,
    parameter int BANK_W   = 3,
    parameter int SLOT_LEN = 4,
    parameter int T_RCD    = 2,
    parameter int RD_LAT   = 3,
    localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [3:0]               req_valid,
    input  logic [3:0]               req_write,
    input  logic [4*ROW_W-1:0]       req_row,
    input  logic [4*COL_W-1:0]       req_col,
    input  logic [4*DATA_W-1:0]      req_wdata,
    input  logic                     ref_req,
    output logic [3:0]               req_take,
    output logic [3:0]               rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    output logic [2:0]               cmd_o,
    output logic                     cmd_rank,
    output logic [BANK_W-1:0]        cmd_bank,
    output logic [ADDR_W-1:0]        cmd_addr,
    output logic                     cmd_ap,
    output logic [DATA_W-1:0]        dq_out,
    output logic                     dq_oe,
    input  logic [DATA_W-1:0]        dq_in
);
    slot_st_e          state;
    logic [GRP_W-1:0]  grp, nxt_grp;
    logic              enter;
    logic              ref_pend;
    logic [ROW_W-1:0]  ref_row;
    logic              consume;

    kind_e             kind_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] wdata_q;
    logic [3:0]        take_q;
    cmd_e              cmd;

    tt_rotor #(.SLOT_LEN(SLOT_LEN), .T_RCD(T_RCD)) u_rotor (
        .clk(clk), .rst(rst), .state_o(state), .grp_o(grp),
        .nxt_grp_o(nxt_grp), .enter_o(enter)
    );

    assign consume = enter & ref_pend;

    tt_refresh #(.ROW_W(ROW_W)) u_refresh (
        .clk(clk), .rst(rst), .ref_req(ref_req), .consume(consume),
        .sel_grp(nxt_grp), .pend_o(ref_pend), .row_o(ref_row)
    );

    // slot contents are fixed on the edge that enters ST_ACT
    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= K_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
            take_q  <= '0;
        end else begin
            take_q <= '0;
            if (enter) begin
                if (ref_pend) begin
                    kind_q <= K_REFRESH;
                    row_q  <= ref_row;
                end else if (req_valid[nxt_grp]) begin
                    kind_q          <= req_write[nxt_grp] ? K_WRITE : K_READ;
                    row_q           <= req_row[nxt_grp*ROW_W +: ROW_W];
                    col_q           <= req_col[nxt_grp*COL_W +: COL_W];
                    wdata_q         <= req_wdata[nxt_grp*DATA_W +: DATA_W];
                    take_q[nxt_grp] <= 1'b1;
                end else begin
                    kind_q <= K_IDLE;
                end
            end
        end
    end

    always_comb begin
        cmd      = CMD_NOP;
        cmd_addr = '0;
        cmd_ap   = 1'b0;
        dq_oe    = 1'b0;
        dq_out   = '0;
        unique case (state)
            ST_ACT: begin
                if (kind_q != K_IDLE) begin
                    cmd      = CMD_ACT;
                    cmd_addr = ADDR_W'(row_q);
                end
            end
            ST_CAS: begin
                unique case (kind_q)
                    K_READ: begin
                        cmd      = CMD_RD;
                        cmd_addr = ADDR_W'(col_q);
                        cmd_ap   = 1'b1;
                    end
                    K_WRITE: begin
                        cmd      = CMD_WR;
                        cmd_addr = ADDR_W'(col_q);
                        cmd_ap   = 1'b1;
                        dq_oe    = 1'b1;
                        dq_out   = wdata_q;
                    end
                    K_REFRESH: cmd = CMD_PRE;
                    K_IDLE:    cmd = CMD_NOP;
                endcase
            end
            ST_RCD, ST_TAIL: cmd = CMD_NOP;
        endcase
    end

    assign cmd_o    = cmd;
    assign cmd_rank = grp[0];
    assign cmd_bank = BANK_W'(grp[1]);
    assign req_take = take_q;

    tt_rdret #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_rdret (
        .clk(clk), .rst(rst),
        .issue((state == ST_CAS) && (kind_q == K_READ)),
        .grp(grp), .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );
endmodule

// File: rtl/tt_bank_sched_chk.sv
module tt_bank_sched_chk #(
    parameter int SLOT_LEN = 4,
    parameter int T_RCD    = 2,
    parameter int RD_LAT   = 3,
    parameter int BANK_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd,
    input logic              rank,
    input logic [BANK_W-1:0] bank,
    input logic              ap,
    input logic              dq_oe,
    input logic [3:0]        take,
    input logic [3:0]        rd_valid
);
    localparam int PH_W = $clog2(SLOT_LEN + 1);

    logic [PH_W-1:0]   ph;
    logic [1:0]        gx;
    logic [7:0]        since_act, since_rd;
    logic              act_rank;
    logic [BANK_W-1:0] act_bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_W'(SLOT_LEN - 1);
            gx        <= 2'd3;
            since_act <= 8'hFF;
            since_rd  <= 8'hFF;
            act_rank  <= 1'b0;
            act_bank  <= '0;
        end else begin
            if (ph == PH_W'(SLOT_LEN - 1)) begin
                ph <= '0;
                gx <= gx + 1'b1;
            end else begin
                ph <= ph + 1'b1;
            end
            if (cmd == 3'd1) begin
                since_act <= 8'd1;
                act_rank  <= rank;
                act_bank  <= bank;
            end else if (since_act != 8'hFF) begin
                since_act <= since_act + 1'b1;
            end
            if (cmd == 3'd2)             since_rd <= 8'd1;
            else if (since_rd != 8'hFF)  since_rd <= since_rd + 1'b1;
        end
    end

    // R2
    take_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take));
    // R2
    act_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd1) |-> (ph == '0));
    // R3
    act_rank_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd1) |-> (rank == gx[0] && bank == BANK_W'(gx[1])));
    // R4
    take_in_act_chk: assert property (@(posedge clk) disable iff (rst)
        (take != 4'd0) |-> (cmd == 3'd1 && take[gx] && ph == '0));
    // R5
    cas_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2 || cmd == 3'd3 || cmd == 3'd4) |->
        (since_act == 8'(T_RCD) && rank == act_rank && bank == act_bank));
    // R5
    cas_autopre_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2 || cmd == 3'd3) |-> ap);
    // R6
    dq_drive_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (cmd == 3'd3));
    // R7
    rdv_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_valid));
    // R7
    rdv_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid != 4'd0) |-> (since_rd == 8'(RD_LAT + 1)));
endmodule

bind tt_bank_sched tt_bank_sched_chk #(
    .SLOT_LEN(SLOT_LEN), .T_RCD(T_RCD), .RD_LAT(RD_LAT), .BANK_W(BANK_W)
) u_chk (
    .clk(clk), .rst(rst), .cmd(cmd_o), .rank(cmd_rank), .bank(cmd_bank),
    .ap(cmd_ap), .dq_oe(dq_oe), .take(req_take), .rd_valid(rd_valid)
);

// File: tb/tb_tt_bank_sched.sv
`timescale 1ns/1ps
module tb_tt_bank_sched;
    localparam int ROW_W = 4, COL_W = 3, DATA_W = 16, BANK_W = 2;
    localparam int RD_LAT = 3, T_RCD = 2, SLOT_LEN = 4;
    localparam int PERIOD = 4 * SLOT_LEN;
    localparam int RD_RET = T_RCD + RD_LAT + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] req_valid = '0, req_write = '0;
    logic [4*ROW_W-1:0]  req_row = '0;
    logic [4*COL_W-1:0]  req_col = '0;
    logic [4*DATA_W-1:0] req_wdata = '0;
    logic ref_req = 1'b0;
    logic [3:0] req_take, rd_valid;
    logic [DATA_W-1:0] rd_data, dq_out, dq_in;
    logic [2:0] cmd_o;
    logic cmd_rank, cmd_ap, dq_oe;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0] cmd_addr;

    always #2 clk = ~clk;

    tt_bank_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .BANK_W(BANK_W), .SLOT_LEN(SLOT_LEN), .T_RCD(T_RCD), .RD_LAT(RD_LAT)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .ref_req(ref_req), .req_take(req_take), .rd_valid(rd_valid),
        .rd_data(rd_data), .cmd_o(cmd_o), .cmd_rank(cmd_rank),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

    int cyc;
    int checks = 0, fails = 0;

    always @(posedge clk) begin
        if (rst) cyc <= -1;
        else     cyc <= cyc + 1;
    end

    // device model, sampled mid-cycle
    logic [DATA_W-1:0] mem [4][16][8];
    logic [ROW_W-1:0]  open_row [4];
    logic [DATA_W-1:0] pipe [RD_LAT+1];
    assign dq_in = pipe[RD_LAT];

    initial begin
        for (int g = 0; g < 4; g++) begin
            open_row[g] = '0;
            for (int r = 0; r < 16; r++)
                for (int c = 0; c < 8; c++) mem[g][r][c] = '0;
        end
        for (int i = 0; i <= RD_LAT; i++) pipe[i] = 16'hDEAD;
    end

    always @(negedge clk) begin
        automatic int g = {cmd_bank[0], cmd_rank};
        for (int i = RD_LAT; i > 0; i--) pipe[i] = pipe[i-1];
        pipe[0] = 16'hDEAD;
        if (!rst) begin
            if (cmd_o == 3'd1) open_row[g] = cmd_addr;
            if (cmd_o == 3'd3) mem[g][open_row[g]][cmd_addr[2:0]] = dq_out;
            if (cmd_o == 3'd2) pipe[0] = mem[g][open_row[g]][cmd_addr[2:0]];
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int next_slot(input int c, input int g);
        int s = c + 1;
        while (((s + PERIOD - g * SLOT_LEN) % PERIOD) != 0) s++;
        return s;
    endfunction

    task automatic do_req(input int g, input bit wr, input int row, input int col,
                          input int data, input int skip, input string tag);
        int c0, ts;
        @(negedge clk);
        c0 = cyc;
        req_valid[g] = 1'b1;
        req_write[g] = wr;
        req_row[g*ROW_W +: ROW_W]    = ROW_W'(row);
        req_col[g*COL_W +: COL_W]    = COL_W'(col);
        req_wdata[g*DATA_W +: DATA_W] = DATA_W'(data);
        do @(negedge clk); while (!req_take[g]);
        ts = cyc;
        req_valid[g] = 1'b0;
        check(ts == next_slot(c0, g) + skip * PERIOD, {tag, " R2 accept slot"},
              ts, next_slot(c0, g) + skip * PERIOD);
        check(cmd_o == 3'd1 && cmd_rank == g[0] && cmd_bank == BANK_W'(g[1]) &&
              cmd_addr == ROW_W'(row), {tag, " R3 R5 ACT row/rank/bank"},
              {cmd_o, cmd_rank, cmd_bank, cmd_addr}, {3'd1, g[0], 2'(g[1]), 4'(row)});
        repeat (T_RCD) @(negedge clk);
        if (wr)
            check(cmd_o == 3'd3 && cmd_ap && cmd_addr == ROW_W'(col) && dq_oe &&
                  dq_out == DATA_W'(data), {tag, " R6 WR pattern"},
                  {cmd_o, cmd_addr, dq_out}, {3'd3, 4'(col), 16'(data)});
        else begin
            check(cmd_o == 3'd2 && cmd_ap && cmd_addr == ROW_W'(col) && !dq_oe,
                  {tag, " R5 RD pattern"}, {cmd_o, cmd_addr}, {3'd2, 4'(col)});
            do @(negedge clk); while (!rd_valid[g]);
            check(cyc - ts == RD_RET, {tag, " R7 return latency"}, cyc - ts, RD_RET);
            check(rd_data == DATA_W'(data), {tag, " R10 read data"}, rd_data, data);
        end
    endtask

    task automatic align(input int m);
        do @(negedge clk); while ((cyc % PERIOD) != m);
    endtask

    task automatic do_refresh(input int g, input int row, input string tag);
        @(negedge clk);
        ref_req = 1'b1;
        @(negedge clk);
        ref_req = 1'b0;
        @(negedge clk);
        check(cmd_o == 3'd1 && cmd_rank == g[0] && cmd_bank == BANK_W'(g[1]) &&
              cmd_addr == ROW_W'(row) && req_take == 4'd0, {tag, " R8 refresh ACT"},
              {cmd_o, cmd_rank, cmd_addr, req_take}, {3'd1, g[0], 4'(row), 4'd0});
        repeat (T_RCD) @(negedge clk);
        check(cmd_o == 3'd4, {tag, " R8 refresh PRE"}, cmd_o, 4);
    endtask

    // group, write, row, col, data (expected data for reads)
    localparam logic [25:0] VECS [10] = '{
        {2'd0, 1'b1, 4'd3,  3'd5, 16'hA1B2},
        {2'd1, 1'b1, 4'd3,  3'd5, 16'hC3D4},
        {2'd2, 1'b1, 4'd9,  3'd0, 16'h5566},
        {2'd3, 1'b1, 4'd15, 3'd7, 16'h7788},
        {2'd0, 1'b0, 4'd3,  3'd5, 16'hA1B2},
        {2'd1, 1'b0, 4'd3,  3'd5, 16'hC3D4},
        {2'd2, 1'b0, 4'd9,  3'd0, 16'h5566},
        {2'd3, 1'b0, 4'd15, 3'd7, 16'h7788},
        {2'd0, 1'b1, 4'd3,  3'd5, 16'h0F0F},
        {2'd0, 1'b0, 4'd3,  3'd5, 16'h0F0F}
    };

    initial begin
        bit idle_ok;
        repeat (3) @(negedge clk);
        check(cmd_o == 3'd0 && req_take == 4'd0 && rd_valid == 4'd0, "R1 in reset",
              {cmd_o, req_take, rd_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(cyc == 0 && cmd_o == 3'd0 && req_take == 4'd0 && rd_valid == 4'd0,
              "R1 first cycle", {cmd_o, req_take, rd_valid}, 0);
        idle_ok = 1'b1;
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            if (cmd_o != 3'd0 || req_take != 4'd0 || dq_oe) idle_ok = 1'b0;
        end
        check(idle_ok, "R4 idle rotation all NOP", idle_ok, 1);

        for (int i = 0; i < 10; i++)
            do_req(VECS[i][25:24], VECS[i][23], VECS[i][22:19], VECS[i][18:16],
                   VECS[i][15:0], 0, "VEC");

        // R9: all groups at once
        align(7);
        fork
            do_req(0, 1'b0, 3,  5, 16'h0F0F, 0, "R9 g0");
            do_req(1, 1'b0, 3,  5, 16'hC3D4, 0, "R9 g1");
            do_req(2, 1'b0, 9,  0, 16'h5566, 0, "R9 g2");
            do_req(3, 1'b0, 15, 7, 16'h7788, 0, "R9 g3");
        join

        // R8: refresh steals group 1's slot, group 2 unaffected
        align(1);
        fork
            do_refresh(1, 0, "R8 g1 first");
            do_req(1, 1'b0, 3, 5, 16'hC3D4, 1, "R8 g1 deferred");
            do_req(2, 1'b0, 9, 0, 16'h5566, 0, "R8 g2 untouched");
        join
        align(13);
        do_refresh(0, 0, "R8 g0 own counter");
        align(1);
        do_refresh(1, 1, "R8 g1 advanced");

        repeat (8) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R2 actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule